// File: doc/BRIEF.md
# Two-Mode Biphase Line Encoder with Loopback Decoder

This block turns parallel bytes into a single biphase line signal. A mode input picks one of two codings. In plain mode the direction of the mid-cell edge carries the bit. In differential mode the presence or absence of an edge at the start of the cell carries the bit. A one-cycle half-bit strobe paces the line, so every bit cell lasts exactly two strobes. Bytes enter through a valid/ready handshake. Ready is timed so that one byte can follow another with no gap on the line.

When no byte is pending, the line settles to a chosen idle level and stays there with no edges. A decoder in the same block samples the line once per half-bit and rebuilds bits and bytes. It gives a loopback view of what was sent. It takes cell alignment from the serializer and does not search for edges.

Top module: `mcode_codec`

## Requirements
- R1: Each bit occupies two consecutive half-bit strobes, and the level in the second half is always the inverse of the first, so every cell has a mid-cell edge in both modes.
- R2: In plain mode (mode = 0), a 1 is sent low then high, and a 0 is sent high then low.
- R3: In differential mode (mode = 1), a 0 makes the first half differ from the line level just before the cell, and a 1 makes it equal to that level. After reset that reference level is low.
- R4: Bits of a byte leave least significant bit first.
- R5: `in_ready` is high only in a cycle where `half_en` is high and the encoder is either idle or ending the second half of the last bit. A byte transfers when `in_valid` and `in_ready` are both high. Its first half appears on the line at that same strobe, so consecutive bytes leave no gap.
- R6: At a ready strobe with no byte offered, the line goes to `idle_lvl` and keeps that level, with no edges, until a byte is accepted.
- R7: `line_out` changes only in the cycle after a cycle in which `half_en` is high.
- R8: The coding mode is captured when a byte is accepted. Changing `mode` while that byte is being sent has no effect on it.
- R9: While reset is high and just after it falls, `line_out` is 0 and `rx_bit_valid` and `rx_byte_valid` are 0.
- R10: One cycle after the strobe that ends a cell, `rx_bit_valid` pulses with the recovered bit on `rx_bit`. After every eighth bit, `rx_byte_valid` pulses in the same cycle, and `rx_byte` holds the byte assembled least significant bit first.
- R11: `in_valid` at a strobe where `in_ready` is low transfers nothing and does not change the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_en | input | 1 | Half-bit strobe, one cycle wide |
| mode | input | 1 | Coding select: 0 plain, 1 differential |
| idle_lvl | input | 1 | Line level when no byte is being sent |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Byte accepted in this cycle if in_valid is high |
| line_out | output | 1 | Encoded line |
| rx_bit_valid | output | 1 | Recovered bit strobe |
| rx_bit | output | 1 | Recovered bit |
| rx_byte_valid | output | 1 | Recovered byte strobe |
| rx_byte | output | 8 | Last recovered byte |

## Verification
`in_ready` is combinational with the strobe, so it is read in the same cycle the strobe is driven. A new line level is due one cycle after each strobe edge, so the bench reads it at the next falling edge. The bench reads it again a cycle later to confirm that it holds between strobes. The decoder's bit and byte pulses come one cycle after the strobe that closes a cell. For the last bit of a stream, that strobe is the one that starts idle, so byte contents are compared only after that idle strobe. A model inside the bench tracks the previous line level and predicts every half-bit level from the mode that was captured when each byte was accepted.

// File: rtl/mcode_pkg.sv
package mcode_pkg;

    typedef enum logic {
        CODE_PLAIN = 1'b0,
        CODE_DIFF  = 1'b1
    } code_mode_e;

    localparam int unsigned HALVES_PER_BIT = 2;

    // Level of the first half of a cell, given the bit and the level before the cell
    function automatic logic first_half_level(code_mode_e m, logic b, logic ref_lvl);
        logic lvl;
        if (m == CODE_PLAIN) lvl = ~b;
        else                 lvl = b ? ref_lvl : ~ref_lvl;
        return lvl;
    endfunction

    // Bit carried by a cell, from the level before it and its two halves
    function automatic logic recover_bit(code_mode_e m, logic ref_lvl, logic first, logic second);
        logic b;
        if (m == CODE_PLAIN) b = second & ~first;
        else                 b = (first == ref_lvl);
        return b;
    endfunction

endpackage

// File: rtl/mcode_serializer.sv
module mcode_serializer
    import mcode_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_en,
    input  code_mode_e        mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              drive_first,
    output logic              drive_second,
    output logic              drive_idle,
    output logic              next_bit,
    output code_mode_e        next_mode,
    output logic              busy_q,
    output logic              second_q,
    output code_mode_e        mode_q
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shift_q;
    logic [CNT_W-1:0]  idx_q;
    logic              last_half;
    logic              slot_open;
    logic              accept;

    assign last_half = busy_q && second_q && (idx_q == LAST_IDX);
    assign slot_open = !busy_q || last_half;
    assign in_ready  = half_en && slot_open;
    assign accept    = in_ready && in_valid;

    assign drive_first  = accept || (half_en && busy_q && second_q && !last_half);
    assign drive_second = half_en && busy_q && !second_q;
    assign drive_idle   = half_en && slot_open && !in_valid;
    assign next_bit     = accept ? in_data[0] : shift_q[1];
    assign next_mode    = accept ? mode : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q  <= '0;
            idx_q    <= '0;
            busy_q   <= 1'b0;
            second_q <= 1'b0;
            mode_q   <= CODE_PLAIN;
        end else if (half_en) begin
            if (slot_open) begin
                idx_q    <= '0;
                second_q <= 1'b0;
                busy_q   <= in_valid;
                if (in_valid) begin
                    shift_q <= in_data;
                    mode_q  <= mode;
                end
            end else if (!second_q) begin
                second_q <= 1'b1;
            end else begin
                second_q <= 1'b0;
                idx_q    <= idx_q + 1'b1;
                shift_q  <= shift_q >> 1;
            end
        end
    end

endmodule

// File: rtl/mcode_line_drv.sv
module mcode_line_drv
    import mcode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_lvl,
    input  logic       drive_first,
    input  logic       drive_second,
    input  logic       drive_idle,
    input  logic       next_bit,
    input  code_mode_e next_mode,
    output logic       line_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
        end else if (drive_first) begin
            line_q <= first_half_level(next_mode, next_bit, line_q);
        end else if (drive_second) begin
            line_q <= ~line_q;
        end else if (drive_idle) begin
            line_q <= idle_lvl;
        end
    end
endmodule

// File: rtl/mcode_decoder.sv
module mcode_decoder
    import mcode_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_en,
    input  logic              line_in,
    input  logic              cell_busy,
    input  logic              cell_second,
    input  code_mode_e        cell_mode,
    output logic              bit_valid,
    output logic              bit_val,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_val
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic              prev_lvl_q;
    logic              first_q;
    logic              ref_q;
    logic [DATA_W-1:0] acc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              cell_bit;
    logic [DATA_W-1:0] acc_next;

    assign cell_bit = recover_bit(cell_mode, ref_q, first_q, line_in);
    assign acc_next = {cell_bit, acc_q[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl_q <= 1'b0;
            first_q    <= 1'b0;
            ref_q      <= 1'b0;
            acc_q      <= '0;
            cnt_q      <= '0;
            bit_valid  <= 1'b0;
            bit_val    <= 1'b0;
            byte_valid <= 1'b0;
            byte_val   <= '0;
        end else begin
            bit_valid  <= 1'b0;
            byte_valid <= 1'b0;
            if (half_en) begin
                prev_lvl_q <= line_in;
                if (cell_busy && !cell_second) begin
                    first_q <= line_in;
                    ref_q   <= prev_lvl_q;
                end
                if (cell_busy && cell_second) begin
                    bit_valid <= 1'b1;
                    bit_val   <= cell_bit;
                    acc_q     <= acc_next;
                    if (cnt_q == LAST_IDX) begin
                        cnt_q      <= '0;
                        byte_valid <= 1'b1;
                        byte_val   <= acc_next;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mcode_codec.sv
module mcode_codec
    import mcode_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_en,
    input  logic              mode,
    input  logic              idle_lvl,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              line_out,
    output logic              rx_bit_valid,
    output logic              rx_bit,
    output logic              rx_byte_valid,
    output logic [DATA_W-1:0] rx_byte
);
    code_mode_e mode_sel;
    logic       drive_first;
    logic       drive_second;
    logic       drive_idle;
    logic       next_bit;
    code_mode_e next_mode;
    logic       tx_busy;
    logic       tx_second;
    code_mode_e tx_mode;

    assign mode_sel = code_mode_e'(mode);

    mcode_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk          (clk),
        .rst          (rst),
        .half_en      (half_en),
        .mode         (mode_sel),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .drive_first  (drive_first),
        .drive_second (drive_second),
        .drive_idle   (drive_idle),
        .next_bit     (next_bit),
        .next_mode    (next_mode),
        .busy_q       (tx_busy),
        .second_q     (tx_second),
        .mode_q       (tx_mode)
    );

    mcode_line_drv u_drv (
        .clk          (clk),
        .rst          (rst),
        .idle_lvl     (idle_lvl),
        .drive_first  (drive_first),
        .drive_second (drive_second),
        .drive_idle   (drive_idle),
        .next_bit     (next_bit),
        .next_mode    (next_mode),
        .line_q       (line_out)
    );

    mcode_decoder #(.DATA_W(DATA_W)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .half_en     (half_en),
        .line_in     (line_out),
        .cell_busy   (tx_busy),
        .cell_second (tx_second),
        .cell_mode   (tx_mode),
        .bit_valid   (rx_bit_valid),
        .bit_val     (rx_bit),
        .byte_valid  (rx_byte_valid),
        .byte_val    (rx_byte)
    );

endmodule

// File: rtl/mcode_codec_props.sv
module mcode_codec_props (
    input logic clk,
    input logic rst,
    input logic half_en,
    input logic in_valid,
    input logic in_ready,
    input logic idle_lvl,
    input logic line_out,
    input logic rx_bit_valid,
    input logic rx_byte_valid,
    input logic tx_busy,
    input logic tx_second
);
    assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (rst)
        !half_en |=> $stable(line_out));

    assert_mid_flip_R1: assert property (@(posedge clk) disable iff (rst)
        (half_en && tx_busy && !tx_second) |=> (line_out != $past(line_out)));

    assert_ready_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> half_en);

    assert_ready_state_R5: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!tx_busy || tx_second));

    assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (line_out == $past(idle_lvl)));

    assert_byte_with_bit_R10: assert property (@(posedge clk) disable iff (rst)
        rx_byte_valid |-> rx_bit_valid);
endmodule

bind mcode_codec mcode_codec_props u_props (
    .clk           (clk),
    .rst           (rst),
    .half_en       (half_en),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .idle_lvl      (idle_lvl),
    .line_out      (line_out),
    .rx_bit_valid  (rx_bit_valid),
    .rx_byte_valid (rx_byte_valid),
    .tx_busy       (tx_busy),
    .tx_second     (tx_second)
);

// File: tb/test_mcode_codec.sv
module test_mcode_codec;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_en = 1'b0;
    logic       mode = 1'b0;
    logic       idle_lvl = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       line_out;
    logic       rx_bit_valid;
    logic       rx_bit;
    logic       rx_byte_valid;
    logic [7:0] rx_byte;

    int total = 0;
    int bad   = 0;

    logic [7:0] tx_buf [0:7];
    logic [7:0] rx_buf [0:7];
    int         rx_cnt = 0;
    int         rx_bits = 0;
    logic       exp_line = 1'b0;

    always #4 clk = ~clk;

    mcode_codec i_mcode_codec (
        .clk           (clk),
        .rst           (rst),
        .half_en       (half_en),
        .mode          (mode),
        .idle_lvl      (idle_lvl),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .line_out      (line_out),
        .rx_bit_valid  (rx_bit_valid),
        .rx_bit        (rx_bit),
        .rx_byte_valid (rx_byte_valid),
        .rx_byte       (rx_byte)
    );

    always @(negedge clk) begin
        if (!rst && rx_bit_valid) rx_bits <= rx_bits + 1;
        if (!rst && rx_byte_valid) begin
            if (rx_cnt < 8) rx_buf[rx_cnt] <= rx_byte;
            rx_cnt <= rx_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One half-bit strobe; returns ready seen with the strobe and the new line level
    task automatic tick(input logic v, input logic [7:0] d, output logic rdy, output logic lvl);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        half_en  = 1'b1;
        #1 rdy = in_ready;
        @(negedge clk);
        half_en  = 1'b0;
        in_valid = 1'b0;
        lvl = line_out;
        @(negedge clk);
        check(line_out == lvl, "R7 line held between strobes", line_out, lvl);
    endtask

    task automatic idle_tick(input string tag);
        logic rdy, lvl;
        tick(1'b0, 8'h00, rdy, lvl);
        check(rdy == 1'b1, {tag, " ready while idle R5"}, rdy, 1);
        check(lvl == idle_lvl, {tag, " idle level R6"}, lvl, idle_lvl);
        exp_line = lvl;
    endtask

    // Send n bytes from tx_buf back to back; noise offers a byte mid-byte, flip toggles mode mid-byte
    task automatic send_stream(input logic m, input int n, input bit noise, input bit flip, input string tag);
        logic rdy, lvl, b, e;
        mode    = m;
        rx_cnt  = 0;
        rx_bits = 0;
        idle_tick(tag);
        for (int k = 0; k < n; k++) begin
            for (int h = 0; h < 16; h++) begin
                logic       v;
                logic [7:0] d;
                v = (h == 0);
                d = tx_buf[k];
                if (noise && h == 5) begin v = 1'b1; d = ~tx_buf[k]; end
                if (flip && h == 4)  mode = ~m;
                if (flip && h == 12) mode = m;
                tick(v, d, rdy, lvl);
                check(rdy == (h == 0), {tag, " ready timing R5/R11"}, rdy, (h == 0));
                b = tx_buf[k][h/2];
                if (h % 2 == 0) begin
                    if (m == 1'b0) e = ~b;
                    else           e = b ? exp_line : ~exp_line;
                end else begin
                    e = ~exp_line;
                end
                check(lvl == e, {tag, " line level R1/R2/R3/R4/R8"}, lvl, e);
                exp_line = lvl;
            end
        end
        idle_tick(tag);
        idle_tick(tag);
        check(rx_cnt == n, {tag, " decoded byte count R10"}, rx_cnt, n);
        check(rx_bits == 8 * n, {tag, " decoded bit count R10"}, rx_bits, 8 * n);
        for (int k = 0; k < n && k < 8; k++)
            check(rx_buf[k] == tx_buf[k], {tag, " decoded byte R10/R4"}, rx_buf[k], tx_buf[k]);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(line_out == 1'b0, "R9 line after reset", line_out, 0);
        check(rx_bit_valid == 1'b0 && rx_byte_valid == 1'b0, "R9 decoder strobes", rx_bit_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(line_out == 1'b0, "R9 line after release", line_out, 0);
        check(in_ready == 1'b0, "R5 no ready without strobe", in_ready, 0);
        exp_line = 1'b0;
    endtask

    task automatic t_plain();
        idle_lvl = 1'b0;
        tx_buf[0] = 8'hA5; tx_buf[1] = 8'h3C; tx_buf[2] = 8'h01;
        send_stream(1'b0, 3, 1'b0, 1'b0, "plain R2");
    endtask

    task automatic t_diff_low();
        idle_lvl = 1'b0;
        tx_buf[0] = 8'h00; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h96;
        send_stream(1'b1, 3, 1'b0, 1'b0, "diff R3");
    endtask

    task automatic t_diff_high();
        idle_lvl = 1'b1;
        tx_buf[0] = 8'h01; tx_buf[1] = 8'h80;
        send_stream(1'b1, 2, 1'b0, 1'b0, "diff idle-high R3");
    endtask

    task automatic t_noise();
        idle_lvl = 1'b1;
        tx_buf[0] = 8'h5A; tx_buf[1] = 8'hE7;
        send_stream(1'b0, 2, 1'b1, 1'b0, "offer while busy R11");
    endtask

    task automatic t_mode_flip();
        idle_lvl = 1'b0;
        tx_buf[0] = 8'hC3; tx_buf[1] = 8'h2D;
        send_stream(1'b1, 2, 1'b0, 1'b1, "mode change R8");
        tx_buf[0] = 8'h4B;
        send_stream(1'b0, 1, 1'b0, 1'b1, "mode change plain R8");
    endtask

    task automatic t_long_idle();
        idle_lvl = 1'b1;
        tx_buf[0] = 8'h7E;
        send_stream(1'b0, 1, 1'b0, 1'b0, "single byte R6");
        for (int i = 0; i < 6; i++) idle_tick("long idle R6");
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_diff_low();
        t_diff_high();
        t_noise();
        t_mode_flip();
        t_long_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule